// File: doc/BRIEF.md
# Register File with Access-Error Response

A 32-bit register block that serves a simple single-outstanding CPU port. Each request is one-cycle `req` pulse carrying direction, byte address, write data and a per-bit write enable. Each request ends with exactly one `rd_ack` or `wr_ack` pulse. Read data and the `err` flag travel with that acknowledge. The block holds three registers of its own: one read-write, one constant read-only and one write-only whose value drives a hardware output. It also forwards accesses to six external targets: three single registers and three two-word memory windows, each with its own request strobe and its own acknowledges.

Every address is decoded against a fixed map, and each target carries a software permission. Two independent parameters choose whether an unmapped address and a permission violation report `err`. A denied access is ended locally and is never forwarded. A write to a read-only target therefore changes nothing, and a read of a write-only target returns zero without touching its contents. This holds whether or not the matching error is enabled.

Top module: `cfg_regfile`

## Requirements
- R1: After reset, `rd_ack`, `wr_ack` and `err` are low, `wo_value` is 100, the read-write register at 0x00 reads 40 and the constant at 0x04 reads 80.
- R2: A write to 0x00 replaces only the bits whose `wr_biten` bit is 1, and a later read returns the merged value.
- R3: A write to 0x08 updates `wo_value` under `wr_biten`. A read of 0x08 returns 0, sets `err` when ERR_BAD_RW is 1, and leaves `wo_value` unchanged.
- R4: A read of 0x04 returns 80. A write to 0x04 sets `err` when ERR_BAD_RW is 1, and the value stays 80.
- R5: A permitted external access raises exactly one `ext_req` bit for one cycle. Bit 0 is the register at 0x0C (rw), bit 1 is 0x10 (read-only), bit 2 is 0x14 (write-only), bit 3 is the window at 0x20 (rw), bit 4 is 0x28 (read-only) and bit 5 is 0x30 (write-only). In that cycle `ext_is_wr`, `ext_wr_data` and `ext_wr_biten` follow the request, and `ext_addr` carries address bit 2 as the word offset inside a window. The access completes one cycle after the matching `ext_rd_ack`/`ext_wr_ack` bit. It returns that target's slice of `ext_rd_data` (bits 32*i+31 down to 32*i) with `err` low.
- R6: A write to an external read-only target or a read of an external write-only target raises no `ext_req`. It is acknowledged one cycle after the request, and a read returns 0. `err` is set when ERR_BAD_RW is 1. The external contents are unchanged.
- R7: An address that hits nothing (for example 0x18, 0x1C or 0x38) is acknowledged one cycle after the request. A read returns 0, a write changes nothing, and `err` is set when ERR_BAD_ADDR is 1.
- R8: ERR_BAD_ADDR and ERR_BAD_RW act independently, and all four combinations give the error behaviour of R3, R4, R6 and R7.
- R9: Each request gets exactly one acknowledge, `rd_ack` and `wr_ack` never rise together, `err` is high only with an acknowledge, and a locally ended access is acknowledged in the cycle after the request.
- R10: A synchronous active-high `rst` restores 40 at 0x00 and 100 on `wo_value`, whatever was written before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle request strobe |
| req_is_wr | input | 1 | 1 for write, 0 for read |
| addr | input | 6 | Byte address |
| wr_data | input | 32 | Write data |
| wr_biten | input | 32 | Per-bit write enable |
| rd_ack | output | 1 | Read completion pulse |
| wr_ack | output | 1 | Write completion pulse |
| rd_data | output | 32 | Read data, valid with `rd_ack` |
| err | output | 1 | Error response, valid with an acknowledge |
| wo_value | output | 32 | Current value of the write-only register |
| ext_req | output | 6 | One-hot request to the external targets |
| ext_is_wr | output | 1 | Direction of the forwarded access |
| ext_addr | output | 1 | Word offset inside a memory window |
| ext_wr_data | output | 32 | Forwarded write data |
| ext_wr_biten | output | 32 | Forwarded per-bit write enable |
| ext_rd_ack | input | 6 | Read acknowledge from each external target |
| ext_wr_ack | input | 6 | Write acknowledge from each external target |
| ext_rd_data | input | 192 | Read data, 32 bits per external target |

## Verification
On every cycle the assertions check that acknowledges are exclusive and that `err` appears only with one. They also check that `ext_req` is at most one-hot, that no write reaches a read-only external target and no read reaches a write-only one, that unmapped requests are never forwarded, that a locally ended access is acknowledged in the next cycle, and that a read never moves `wo_value`. Only the bench's scenarios can show the data itself: the reset values, the bit-enable merges, the contents of the external models after denied writes, the zero returned by forbidden and unmapped reads, and the error flag under each of the four enable combinations running side by side.

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter bit ERR_BAD_ADDR = 1'b1,
  parameter bit ERR_BAD_RW = 1'b1,
  parameter logic [DW-1:0] RW_INIT = DW'(40),
  parameter logic [DW-1:0] RO_CONST = DW'(80),
  parameter logic [DW-1:0] WO_INIT = DW'(100)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_is_wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     wr_biten,
  output logic              rd_ack,
  output logic              wr_ack,
  output logic [DW-1:0]     rd_data,
  output logic              err,
  output logic [DW-1:0]     wo_value,
  output logic [5:0]        ext_req,
  output logic              ext_is_wr,
  output logic              ext_addr,
  output logic [DW-1:0]     ext_wr_data,
  output logic [DW-1:0]     ext_wr_biten,
  input  logic [5:0]        ext_rd_ack,
  input  logic [5:0]        ext_wr_ack,
  input  logic [6*DW-1:0]   ext_rd_data
);
  localparam int NX = 6;
  localparam int WW = AW - 2;
  localparam logic [NX-1:0] RO_MASK = 6'b010010;
  localparam logic [NX-1:0] WO_MASK = 6'b100100;
  localparam logic [1:0] I_NONE = 2'd0, I_RW = 2'd1, I_RO = 2'd2, I_WO = 2'd3;

  logic [WW-1:0] word;
  logic          addr_lo_unused;
  logic          mapped, can_rd, can_wr, perm_ok, fwd, local_go, ext_done;
  logic [1:0]    isel;
  logic [NX-1:0] xsel, p_sel;
  logic          pend, p_wr;
  logic [DW-1:0] r_rw, ext_mux;

  assign word = addr[AW-1:2];
  assign addr_lo_unused = ^addr[1:0];

  always_comb begin
    mapped = 1'b1; can_rd = 1'b1; can_wr = 1'b1; isel = I_NONE; xsel = '0;
    case (word)
      WW'(0):  isel = I_RW;
      WW'(1):  begin isel = I_RO; can_wr = 1'b0; end
      WW'(2):  begin isel = I_WO; can_rd = 1'b0; end
      WW'(3):  xsel = 6'b000001;
      WW'(4):  begin xsel = 6'b000010; can_wr = 1'b0; end
      WW'(5):  begin xsel = 6'b000100; can_rd = 1'b0; end
      WW'(8), WW'(9):   xsel = 6'b001000;
      WW'(10), WW'(11): begin xsel = 6'b010000; can_wr = 1'b0; end
      WW'(12), WW'(13): begin xsel = 6'b100000; can_rd = 1'b0; end
      default: begin mapped = 1'b0; can_rd = 1'b0; can_wr = 1'b0; end
    endcase
  end

  assign perm_ok  = req_is_wr ? can_wr : can_rd;
  assign fwd      = mapped & perm_ok & (|xsel);
  assign local_go = req & ~pend & ~fwd;
  assign ext_req  = (req & ~pend & fwd) ? xsel : '0;
  assign ext_is_wr    = req_is_wr;
  assign ext_addr     = addr[2];
  assign ext_wr_data  = wr_data;
  assign ext_wr_biten = wr_biten;
  assign ext_done = pend & |(p_sel & (p_wr ? ext_wr_ack : ext_rd_ack));

  always_comb begin
    ext_mux = '0;
    for (int i = 0; i < NX; i++)
      if (p_sel[i]) ext_mux |= ext_rd_data[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_rw <= RW_INIT; wo_value <= WO_INIT;
      pend <= 1'b0; p_sel <= '0; p_wr <= 1'b0;
      rd_ack <= 1'b0; wr_ack <= 1'b0; err <= 1'b0; rd_data <= '0;
    end else begin
      rd_ack <= 1'b0; wr_ack <= 1'b0; err <= 1'b0;
      if (local_go) begin
        rd_ack <= ~req_is_wr;
        wr_ack <= req_is_wr;
        err    <= mapped ? (~perm_ok & ERR_BAD_RW) : ERR_BAD_ADDR;
        if (!req_is_wr)
          rd_data <= (perm_ok && isel == I_RW) ? r_rw :
                     (perm_ok && isel == I_RO) ? RO_CONST : '0;
        else if (perm_ok && isel == I_RW)
          r_rw <= (r_rw & ~wr_biten) | (wr_data & wr_biten);
        else if (perm_ok && isel == I_WO)
          wo_value <= (wo_value & ~wr_biten) | (wr_data & wr_biten);
      end
      if (req && !pend && fwd) begin
        pend <= 1'b1; p_sel <= xsel; p_wr <= req_is_wr;
      end
      if (ext_done) begin
        pend <= 1'b0;
        rd_ack <= ~p_wr;
        wr_ack <= p_wr;
        if (!p_wr) rd_data <= ext_mux;
      end
    end
  end

  p_ack_excl_r9: assert property (@(posedge clk) disable iff (rst) !(rd_ack && wr_ack));
  p_err_with_ack_r9: assert property (@(posedge clk) disable iff (rst) err |-> (rd_ack || wr_ack));
  p_local_next_r9: assert property (@(posedge clk) disable iff (rst)
    (req && !pend && !fwd) |=> (rd_ack || wr_ack));
  p_ext_onehot_r5: assert property (@(posedge clk) disable iff (rst) $onehot0(ext_req));
  p_no_ro_write_r6: assert property (@(posedge clk) disable iff (rst)
    (|(ext_req & RO_MASK)) |-> !ext_is_wr);
  p_no_wo_read_r6: assert property (@(posedge clk) disable iff (rst)
    (|(ext_req & WO_MASK)) |-> ext_is_wr);
  p_unmapped_local_r7: assert property (@(posedge clk) disable iff (rst)
    (req && !mapped) |-> (ext_req == '0));
  p_wo_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (req && !req_is_wr) |=> $stable(wo_value));
endmodule

// File: tb/cfg_regfile_bench.sv
module cfg_regfile_bench;
  typedef struct packed {
    logic        wr;
    logic [5:0]  a;
    logic [31:0] wd;
    logic [31:0] be;
    logic [31:0] rd;
    logic        e;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h00, 32'h0, 32'h0, 32'd40, 1'b0, 4'd1},                        // R1
    '{1'b1, 6'h00, 32'h12345678, 32'hFFFF0000, 32'h0, 1'b0, 4'd2},           // R2
    '{1'b0, 6'h00, 32'h0, 32'h0, 32'h12340028, 1'b0, 4'd2},                  // R2
    '{1'b0, 6'h04, 32'h0, 32'h0, 32'd80, 1'b0, 4'd4},                        // R4
    '{1'b1, 6'h04, 32'd81, 32'hFFFFFFFF, 32'h0, 1'b1, 4'd4},                 // R4
    '{1'b0, 6'h04, 32'h0, 32'h0, 32'd80, 1'b0, 4'd4},                        // R4
    '{1'b0, 6'h08, 32'h0, 32'h0, 32'h0, 1'b1, 4'd3},                         // R3
    '{1'b1, 6'h08, 32'd101, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd3},                // R3
    '{1'b0, 6'h0C, 32'h0, 32'h0, 32'h8C, 1'b0, 4'd5},                        // R5
    '{1'b1, 6'h0C, 32'h8D, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd5},                 // R5
    '{1'b0, 6'h0C, 32'h0, 32'h0, 32'h8D, 1'b0, 4'd5},                        // R5
    '{1'b0, 6'h10, 32'h0, 32'h0, 32'hB4, 1'b0, 4'd5},                        // R5
    '{1'b1, 6'h10, 32'hB5, 32'hFFFFFFFF, 32'h0, 1'b1, 4'd6},                 // R6
    '{1'b0, 6'h10, 32'h0, 32'h0, 32'hB4, 1'b0, 4'd6},                        // R6
    '{1'b0, 6'h14, 32'h0, 32'h0, 32'h0, 1'b1, 4'd6},                         // R6
    '{1'b1, 6'h14, 32'hC9, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd5},                 // R5
    '{1'b0, 6'h18, 32'h0, 32'h0, 32'h0, 1'b1, 4'd7},                         // R7
    '{1'b1, 6'h18, 32'h8C, 32'hFFFFFFFF, 32'h0, 1'b1, 4'd7},                 // R7
    '{1'b0, 6'h24, 32'h0, 32'h0, 32'h22, 1'b0, 4'd5},                        // R5
    '{1'b1, 6'h20, 32'hFFFFFFAB, 32'h000000FF, 32'h0, 1'b0, 4'd5},           // R5
    '{1'b0, 6'h20, 32'h0, 32'h0, 32'hAB, 1'b0, 4'd5},                        // R5
    '{1'b0, 6'h2C, 32'h0, 32'h0, 32'h44, 1'b0, 4'd5},                        // R5
    '{1'b1, 6'h28, 32'h99, 32'hFFFFFFFF, 32'h0, 1'b1, 4'd6},                 // R6
    '{1'b0, 6'h28, 32'h0, 32'h0, 32'h33, 1'b0, 4'd6},                        // R6
    '{1'b0, 6'h30, 32'h0, 32'h0, 32'h0, 1'b1, 4'd6},                         // R6
    '{1'b1, 6'h34, 32'h77, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd5},                 // R5
    '{1'b0, 6'h1C, 32'h0, 32'h0, 32'h0, 1'b1, 4'd7},                         // R7
    '{1'b0, 6'h38, 32'h0, 32'h0, 32'h0, 1'b1, 4'd7}                          // R7
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_m = 1'b0, req_a = 1'b0, d_wr = 1'b0;
  logic [5:0] d_addr = '0;
  logic [31:0] d_wd = '0, d_be = '0;
  logic rd_ack, wr_ack, err, ext_is_wr, ext_addr;
  logic [31:0] rd_data, wo_value, ext_wr_data, ext_wr_biten;
  logic [5:0] ext_req, m_rd_ack, m_wr_ack;
  logic [191:0] m_rd_data;
  int n_chk = 0, n_fail = 0, bad_fwd = 0, alt_fwd = 0;

  always #4 clk = ~clk;

  cfg_regfile u_cfg_regfile (
    .clk(clk), .rst(rst), .req(req_m), .req_is_wr(d_wr), .addr(d_addr),
    .wr_data(d_wd), .wr_biten(d_be), .rd_ack(rd_ack), .wr_ack(wr_ack),
    .rd_data(rd_data), .err(err), .wo_value(wo_value), .ext_req(ext_req),
    .ext_is_wr(ext_is_wr), .ext_addr(ext_addr), .ext_wr_data(ext_wr_data),
    .ext_wr_biten(ext_wr_biten), .ext_rd_ack(m_rd_ack), .ext_wr_ack(m_wr_ack),
    .ext_rd_data(m_rd_data));

  logic [2:0] a_rd_ack, a_wr_ack, a_err, a_xw, a_xa;
  logic [31:0] a_rd_data [3];
  logic [31:0] a_wo [3];
  logic [31:0] a_xd [3];
  logic [31:0] a_xb [3];
  logic [5:0] a_xreq [3];

  for (genvar g = 0; g < 3; g++) begin : g_alt
    cfg_regfile #(.ERR_BAD_ADDR(g == 2), .ERR_BAD_RW(g == 1)) u_alt (
      .clk(clk), .rst(rst), .req(req_a), .req_is_wr(d_wr), .addr(d_addr),
      .wr_data(d_wd), .wr_biten(d_be), .rd_ack(a_rd_ack[g]), .wr_ack(a_wr_ack[g]),
      .rd_data(a_rd_data[g]), .err(a_err[g]), .wo_value(a_wo[g]), .ext_req(a_xreq[g]),
      .ext_is_wr(a_xw[g]), .ext_addr(a_xa[g]), .ext_wr_data(a_xd[g]),
      .ext_wr_biten(a_xb[g]), .ext_rd_ack(6'b0), .ext_wr_ack(6'b0),
      .ext_rd_data(192'b0));
  end

  logic [31:0] st [6][2];
  logic mp, mwr, ma;
  int mi;
  logic [31:0] md, mb;

  always @(posedge clk) begin
    m_rd_ack <= '0;
    m_wr_ack <= '0;
    if (rst) begin
      st[0][0] <= 32'h8C; st[1][0] <= 32'hB4; st[2][0] <= 32'hC8;
      st[0][1] <= 0; st[1][1] <= 0; st[2][1] <= 0;
      st[3][0] <= 32'h11; st[3][1] <= 32'h22; st[4][0] <= 32'h33;
      st[4][1] <= 32'h44; st[5][0] <= 32'h55; st[5][1] <= 32'h66;
      mp <= 1'b0; m_rd_data <= '0;
    end else begin
      if (ext_req != 0) begin
        for (int i = 0; i < 6; i++) if (ext_req[i]) mi <= i;
        mp <= 1'b1; mwr <= ext_is_wr; md <= ext_wr_data; mb <= ext_wr_biten;
        ma <= ext_addr;
      end
      if (mp) begin
        mp <= 1'b0;
        if (mwr) begin
          st[mi][(mi >= 3) ? ma : 1'b0] <= (st[mi][(mi >= 3) ? ma : 1'b0] & ~mb) | (md & mb);
          m_wr_ack[mi] <= 1'b1;
        end else begin
          m_rd_data[mi*32 +: 32] <= st[mi][(mi >= 3) ? ma : 1'b0];
          m_rd_ack[mi] <= 1'b1;
        end
      end
    end
  end

  always @(negedge clk) if (!rst) begin
    if ((|(ext_req & 6'b010010)) && ext_is_wr) bad_fwd++;
    if ((|(ext_req & 6'b100100)) && !ext_is_wr) bad_fwd++;
    for (int g = 0; g < 3; g++) if (a_xreq[g] != 0) alt_fwd++;
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  logic [31:0] c_rd;
  logic c_err;
  int c_lat, c_nack;
  logic [2:0] ca_ack, ca_err;
  logic [31:0] ca_rd [3];

  task automatic access(input logic wr, input logic [5:0] a, input logic [31:0] wd,
                        input logic [31:0] be, input bit alt);
    @(negedge clk);
    d_wr = wr; d_addr = a; d_wd = wd; d_be = be; req_m = 1'b1; req_a = alt;
    @(negedge clk);
    req_m = 1'b0; req_a = 1'b0;
    c_lat = 1; c_nack = 0;
    ca_ack = a_rd_ack | a_wr_ack; ca_err = a_err;
    for (int g = 0; g < 3; g++) ca_rd[g] = a_rd_data[g];
    while (!(rd_ack || wr_ack) && c_lat < 20) begin
      @(negedge clk);
      c_lat++;
    end
    c_rd = rd_data; c_err = err;
    if (rd_ack || wr_ack) c_nack = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (rd_ack || wr_ack) c_nack++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ack idle", {30'b0, rd_ack, wr_ack}, 32'h0);
    check("R1 err idle", {31'b0, err}, 32'h0);
    check("R1 wo_value", wo_value, 32'd100);

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].wr, VECS[v].a, VECS[v].wd, VECS[v].be, 1'b0);
      if (c_nack != 1)
        $display("FAIL R9 vector %0d: actual %0d acks expected 1", v, c_nack);
      check("R9 one ack", 32'(c_nack), 32'd1);
      if (c_err !== VECS[v].e)
        $display("FAIL R%0d vector %0d err: actual %0b expected %0b", VECS[v].rq, v, c_err, VECS[v].e);
      n_chk++; if (c_err !== VECS[v].e) n_fail++;
      if (!VECS[v].wr) begin
        n_chk++;
        if (c_rd !== VECS[v].rd) begin
          n_fail++;
          $display("FAIL R%0d vector %0d data: actual %0h expected %0h", VECS[v].rq, v, c_rd, VECS[v].rd);
        end
      end
      if (VECS[v].a == 6'h18 || VECS[v].a == 6'h04 || VECS[v].a == 6'h08)
        check("R9 local latency", 32'(c_lat), 32'd1);
    end

    check("R3 wo_value after write", wo_value, 32'd101);
    check("R5 ext wo reg written", st[2][0], 32'hC9);
    check("R5 mem wo word1 written", st[5][1], 32'h77);
    check("R5 mem wo word0 kept", st[5][0], 32'h55);
    check("R6 ext ro reg kept", st[1][0], 32'hB4);
    check("R6 mem ro kept", st[4][0], 32'h33);
    check("R6 no forbidden forward", 32'(bad_fwd), 32'd0);

    // R8: four enable combinations side by side (main is 1/1, alt g: 0/0, 0/1, 1/0)
    for (int t = 0; t < 7; t++) begin
      logic w; logic [5:0] ad; bit unm;
      case (t)
        0: begin w = 0; ad = 6'h18; unm = 1; end
        1: begin w = 1; ad = 6'h18; unm = 1; end
        2: begin w = 1; ad = 6'h04; unm = 0; end
        3: begin w = 0; ad = 6'h08; unm = 0; end
        4: begin w = 1; ad = 6'h10; unm = 0; end
        5: begin w = 0; ad = 6'h30; unm = 0; end
        default: begin w = 1; ad = 6'h2C; unm = 0; end
      endcase
      access(w, ad, 32'hDEAD, 32'hFFFFFFFF, 1'b1);
      check("R8 main err", {31'b0, c_err}, 32'h1);
      for (int g = 0; g < 3; g++) begin
        check("R8 alt ack", {31'b0, ca_ack[g]}, 32'h1);
        check("R8 alt err", {31'b0, ca_err[g]}, unm ? {31'b0, g == 2} : {31'b0, g == 1});
        if (!w) check("R8 alt read zero", ca_rd[g], 32'h0);
      end
    end
    access(1'b0, 6'h04, 32'h0, 32'h0, 1'b1);
    for (int g = 0; g < 3; g++) begin
      check("R8 alt const kept", ca_rd[g], 32'd80);
      check("R8 alt wo kept", a_wo[g], 32'd100);
    end
    check("R8 alt no forward", 32'(alt_fwd), 32'd0);

    access(1'b1, 6'h00, 32'd5, 32'hFFFFFFFF, 1'b0);
    access(1'b0, 6'h00, 32'h0, 32'h0, 1'b0);
    check("R10 pre-reset value", c_rd, 32'd5);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R10 wo_value restored", wo_value, 32'd100);
    access(1'b0, 6'h00, 32'h0, 32'h0, 1'b0);
    check("R10 rw restored", c_rd, 32'd40);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule